// File: doc/BRIEF.md
# Power-Up Strap Capture and Clock Mode Decoder

This block belongs to a clock synthesizer. It latches the board strap inputs once at power-up and turns them into the static controls that configure the clock tree. After reset is released it counts a settling window of reference-clock cycles. It then waits for an active-low power-good level. On the first clock edge that sees that level low, it captures the mode level, the two frequency-select bits and the drive-current select. From then on the strobe and the straps are ignored until the next reset.

The mode strap comes from a three-level comparator, already resolved into a 2-bit code. Low and high mode are both normal operation and differ only in where the 66 MHz buffers and the PCI clocks take their source. The mid level selects one of these by the frequency bits:
- tri-state of all outputs;
- a test mode, in which a divider chain running on the reference clock gives /2, /4 and /8 taps;
- a reserved code, which is handled like tri-state and raises an error flag.

The captured straps are also presented as read-only status bits for a register file.

Top module: `strap_mode_ctrl`

## Requirements
- R1: A settle window of SETTLE_CYC reference cycles follows reset release. With the strobe held low from reset, `ready_o` is 0 through the first SETTLE_CYC+1 clock edges and is 1 after edge SETTLE_CYC+2. A low strobe before that is ignored.
- R2: Once the settle window is over, the block samples the straps on the first edge at which `pwrgd_ni` is 0 and captures the values present at that edge. While the strobe stays 1, `ready_o` stays 0.
- R3: After sampling, later changes on `pwrgd_ni`, `mode_i`, `fsel_i` and `mult_i` have no effect on any output until reset.
- R4: Before sampling, these outputs are all 0: `out_en_o`, `hiz_o`, `ext66_sel_o`, `test_mode_o`, `err_o`, `status_o`, `cpu_freq_o`, `mult_o` and `tdiv_o`.
- R5: Mode code 2'b00 (low) gives `out_en_o`=1, `ext66_sel_o`=0 and `cpu_freq_o`=fsel. The fsel encoding is 00=66 MHz, 01=100 MHz, 10=200 MHz, 11=133 MHz.
- R6: Mode code 2'b10 (high) gives `out_en_o`=1, `ext66_sel_o`=1 and `cpu_freq_o`=fsel. In this mode the 66 MHz buffers follow the external input and PCI runs at that input divided by 2.
- R7: Mode code 2'b01 (mid) with fsel 00 gives `hiz_o`=1, `out_en_o`=0 and `err_o`=0.
- R8: Mid mode with fsel 01 gives `test_mode_o`=1, `out_en_o`=1 and `cpu_freq_o`=0. `tdiv_o` counts up by one each cycle, modulo 8, so bit0 is the /2 tap, bit1 the /4 tap and bit2 the /8 tap.
- R9: Mid mode with fsel 10 or 11, or mode code 2'b11, gives `hiz_o`=1, `out_en_o`=0 and `err_o`=1. The error stays set until reset.
- R10: After sampling, `status_o` = {captured mode was high, fsel[1], fsel[0]} and `mult_o` is the captured current select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pwrgd_ni | input | 1 | Power-good strobe, active low, level sensitive |
| mode_i | input | 2 | Resolved mode level: 00 low, 01 mid, 10 high, 11 invalid |
| fsel_i | input | 2 | Frequency select straps |
| mult_i | input | 1 | Output current multiplier strap |
| ready_o | output | 1 | Straps captured, controls valid |
| cpu_freq_o | output | 2 | CPU frequency code in normal modes |
| mult_o | output | 1 | Captured current multiplier |
| ext66_sel_o | output | 1 | 66 MHz buffers and PCI derived from external 66 MHz input |
| out_en_o | output | 1 | Clock outputs enabled |
| hiz_o | output | 1 | All outputs high impedance |
| test_mode_o | output | 1 | Test-clock mode active |
| tdiv_o | output | 3 | Test divider taps /2, /4, /8 |
| status_o | output | 3 | Read-only strap status for the register file |
| err_o | output | 1 | Sticky reserved-mode error |

## Verification
The end of the settle window and the power-good strobe can fall in the same cycle. To provoke this, the strobe is held low from reset and the strap values are changed on the cycles around the boundary. A correct design ignores the strobe during the last settle cycle and captures exactly the straps present on the first edge after the window. The bench judges this by the cycle on which `ready_o` rises and by the status it reports. Strap changes right after capture, in the same cycle the test divider starts counting, must leave the status untouched while `tdiv_o` advances.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {LVL_LO = 2'b00, LVL_MID = 2'b01, LVL_HI = 2'b10, LVL_BAD = 2'b11} lvl_e;
  typedef enum logic [1:0] {ST_OFF, ST_SETTLE, ST_WAIT, ST_RUN} seq_e;
  typedef struct packed {
    logic out_en;
    logic hiz;
    logic ext66;
    logic test;
    logic err;
  } ctl_t;
endpackage

// File: rtl/strap_seq.sv
module strap_seq #(
  parameter int SETTLE_CYC = 3580
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrgd_ni,
  output logic sample_o,
  output logic run_o
);
  import strap_pkg::*;
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  seq_e st_q, st_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:    st_d = ST_SETTLE;
      ST_SETTLE: if (cnt_q == LAST) st_d = ST_WAIT;
      ST_WAIT:   if (!pwrgd_ni) st_d = ST_RUN;
      default:   st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_SETTLE) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sample_o = (st_q == ST_WAIT) && !pwrgd_ni;
  assign run_o    = (st_q == ST_RUN);
endmodule

// File: rtl/strap_decode.sv
module strap_decode (
  input  logic                 run_i,
  input  strap_pkg::lvl_e      lvl_i,
  input  logic [1:0]           fsel_i,
  output strap_pkg::ctl_t      ctl_o,
  output logic [1:0]           cpu_freq_o
);
  import strap_pkg::*;
  always_comb begin
    ctl_o      = '0;
    cpu_freq_o = 2'b00;
    if (run_i) begin
      unique case (lvl_i)
        LVL_LO: begin
          ctl_o.out_en = 1'b1;
          cpu_freq_o   = fsel_i;
        end
        LVL_HI: begin
          ctl_o.out_en = 1'b1;
          ctl_o.ext66  = 1'b1;
          cpu_freq_o   = fsel_i;
        end
        LVL_MID: begin
          unique case (fsel_i)
            2'b00: ctl_o.hiz = 1'b1;
            2'b01: begin
              ctl_o.test   = 1'b1;
              ctl_o.out_en = 1'b1;
            end
            default: begin
              ctl_o.hiz = 1'b1;
              ctl_o.err = 1'b1;
            end
          endcase
        end
        default: begin
          ctl_o.hiz = 1'b1;
          ctl_o.err = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/tclk_div.sv
module tclk_div #(
  parameter int STAGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [STAGES-1:0] div_o
);
  logic [STAGES-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
    else           cnt_q <= '0;
  end
  // bit k toggles at clk/2^(k+1)
  assign div_o = cnt_q;
endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl #(
  parameter int SETTLE_CYC = 3580,
  parameter int DIV_STAGES = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pwrgd_ni,
  input  logic [1:0]            mode_i,
  input  logic [1:0]            fsel_i,
  input  logic                  mult_i,
  output logic                  ready_o,
  output logic [1:0]            cpu_freq_o,
  output logic                  mult_o,
  output logic                  ext66_sel_o,
  output logic                  out_en_o,
  output logic                  hiz_o,
  output logic                  test_mode_o,
  output logic [DIV_STAGES-1:0] tdiv_o,
  output logic [2:0]            status_o,
  output logic                  err_o
);
  import strap_pkg::*;

  logic sample, run;
  lvl_e lvl_q;
  logic [1:0] fsel_q;
  logic mult_q;
  ctl_t ctl;

  strap_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwrgd_ni(pwrgd_ni),
    .sample_o(sample), .run_o(run)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= LVL_LO;
      fsel_q <= '0;
      mult_q <= 1'b0;
    end else if (sample) begin
      lvl_q  <= lvl_e'(mode_i);
      fsel_q <= fsel_i;
      mult_q <= mult_i;
    end
  end

  strap_decode u_dec (
    .run_i(run), .lvl_i(lvl_q), .fsel_i(fsel_q),
    .ctl_o(ctl), .cpu_freq_o(cpu_freq_o)
  );

  tclk_div #(.STAGES(DIV_STAGES)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctl.test), .div_o(tdiv_o)
  );

  assign ready_o     = run;
  assign mult_o      = mult_q;
  assign ext66_sel_o = ctl.ext66;
  assign out_en_o    = ctl.out_en;
  assign hiz_o       = ctl.hiz;
  assign test_mode_o = ctl.test;
  assign err_o       = ctl.err;
  assign status_o    = {(lvl_q == LVL_HI), fsel_q};
endmodule

// File: rtl/strap_mode_chk.sv
module strap_mode_chk #(
  parameter int DIV_STAGES = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  pwrgd_ni,
  input logic                  ready_o,
  input logic                  out_en_o,
  input logic                  hiz_o,
  input logic                  test_mode_o,
  input logic                  ext66_sel_o,
  input logic [DIV_STAGES-1:0] tdiv_o,
  input logic [2:0]            status_o,
  input logic                  mult_o,
  input logic                  err_o
);
  // R2
  sample_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(!pwrgd_ni));
  // R3
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o && $stable(status_o) && $stable(mult_o));
  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !out_en_o && !hiz_o && !test_mode_o && !ext66_sel_o && !err_o);
  // R7
  en_hiz_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_en_o && hiz_o));
  // R8
  tdiv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_o && $past(test_mode_o) |-> tdiv_o == $past(tdiv_o) + 1'b1);
  // R8
  tdiv_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_o |=> tdiv_o == '0);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && hiz_o);
endmodule

bind strap_mode_ctrl strap_mode_chk #(.DIV_STAGES(DIV_STAGES)) u_chk (.*);

// File: tb/tb_strap_mode_ctrl.sv
module tb_strap_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 20;

  logic clk = 0, rst_n = 0, pwrgd_n = 1, mult = 0;
  logic [1:0] mode = 0, fsel = 0;
  logic ready, mult_o, ext66, out_en, hiz, test_m, err;
  logic [1:0] cpu_freq;
  logic [2:0] tdiv, status;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_mode_ctrl #(.SETTLE_CYC(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwrgd_ni(pwrgd_n), .mode_i(mode),
    .fsel_i(fsel), .mult_i(mult), .ready_o(ready), .cpu_freq_o(cpu_freq),
    .mult_o(mult_o), .ext66_sel_o(ext66), .out_en_o(out_en), .hiz_o(hiz),
    .test_mode_o(test_m), .tdiv_o(tdiv), .status_o(status), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; pwrgd_n = 1;
    cyc(2);
    rst_n = 1;
  endtask

  // strobe low from reset, straps applied; ready after N+2 edges
  task automatic boot(input logic [1:0] m, input logic [1:0] f, input logic mu);
    do_reset();
    mode = m; fsel = f; mult = mu; pwrgd_n = 0;
    cyc(N + 2);
  endtask

  task automatic t_reset_state();
    do_reset();
    mode = 2'b10; fsel = 2'b11; mult = 1;
    cyc(3);
    chk("R4 out_en", out_en, 0); chk("R4 hiz", hiz, 0);
    chk("R4 status", status, 0); chk("R4 err", err, 0);
    chk("R4 tdiv", tdiv, 0); chk("R4 mult", mult_o, 0);
    chk("R4 cpu_freq", cpu_freq, 0); chk("R4 ext66", ext66, 0);
  endtask

  task automatic t_settle_boundary();
    do_reset();
    pwrgd_n = 0; mode = 2'b01; fsel = 2'b11;
    cyc(N + 1);
    chk("R1 ready before window end", ready, 0);
    mode = 2'b00; fsel = 2'b10; mult = 1;
    cyc(1);
    chk("R1 ready at N+2", ready, 1);
    chk("R1 captured after window", status, 3'b010);
    chk("R5 200MHz code", cpu_freq, 2);
    chk("R10 mult", mult_o, 1);
  endtask

  task automatic t_wait_strobe();
    do_reset();
    mode = 2'b10; fsel = 2'b01; mult = 0;
    cyc(N + 10);
    chk("R2 waits for strobe", ready, 0);
    pwrgd_n = 0;
    cyc(1);
    chk("R2 ready after strobe", ready, 1);
    chk("R6 ext66", ext66, 1); chk("R6 out_en", out_en, 1);
    chk("R6 cpu_freq", cpu_freq, 1);
    chk("R10 status hi", status, 3'b101);
    // R3: changes after capture ignored
    pwrgd_n = 1; mode = 2'b01; fsel = 2'b00; mult = 1;
    cyc(4);
    chk("R3 status held", status, 3'b101); chk("R3 ready held", ready, 1);
    chk("R3 ext66 held", ext66, 1); chk("R3 mult held", mult_o, 0);
    chk("R3 hiz unaffected", hiz, 0);
  endtask

  task automatic t_low_codes();
    for (int f = 0; f < 4; f++) begin
      boot(2'b00, 2'(f), 0);
      chk("R5 out_en", out_en, 1); chk("R5 ext66", ext66, 0);
      chk("R5 cpu_freq", cpu_freq, f); chk("R10 status lo", status, f);
    end
  endtask

  task automatic t_mid_hiz();
    boot(2'b01, 2'b00, 0);
    chk("R7 hiz", hiz, 1); chk("R7 out_en", out_en, 0); chk("R7 err", err, 0);
  endtask

  task automatic t_mid_test();
    int a;
    boot(2'b01, 2'b01, 1);
    chk("R8 test", test_m, 1); chk("R8 out_en", out_en, 1);
    chk("R8 cpu_freq", cpu_freq, 0);
    a = tdiv;
    mode = 2'b10; fsel = 2'b11;
    for (int i = 1; i <= 9; i++) begin
      cyc(1);
      chk("R8 tdiv step", tdiv, (a + i) % 8);
    end
    chk("R3 status after strap change", status, 3'b001);
  endtask

  task automatic t_reserved();
    boot(2'b01, 2'b10, 0);
    chk("R9 hiz", hiz, 1); chk("R9 err", err, 1); chk("R9 out_en", out_en, 0);
    boot(2'b01, 2'b11, 0);
    chk("R9 err 11", err, 1);
    boot(2'b11, 2'b00, 0);
    chk("R9 bad code err", err, 1); chk("R9 bad code hiz", hiz, 1);
    cyc(5);
    chk("R9 sticky", err, 1);
    do_reset(); cyc(1);
    chk("R9 cleared by reset", err, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_settle_boundary();
        t_wait_strobe();
        t_low_codes();
        t_mid_hiz();
        t_mid_test();
        t_reserved();
      end
      begin
        cyc(50000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule